// File: doc/BRIEF.md
# Bus Fault Emulation Injector

This block sits between a DMA engine and the system fabric, on both its read interface and its write interface. It deliberately corrupts chosen bus signals so that the end-to-end integrity checkers further down the path can be shown to detect faults. Software programs a target address, a target signal group (control or data, on the read or the write interface) and a bit code. It then arms the block through a key-guarded configuration register. While the block is armed, every access whose address equals the target address has the chosen signal bit inverted as it passes through. Two adjacent data bits can be inverted instead of one.

The corruption is a combinational XOR applied during the cycle of the matching access. In every other cycle, every signal passes through unchanged. Register reads are combinational from a 4-bit byte offset. Register writes take effect at the rising clock edge.

Top module: `fi_top`

## Requirements
- R1: After reset, all four registers read zero, and all bus outputs equal their inputs.
- R2: A write to offset 0x0 changes the configuration only when bits 15:8 of the write data equal 0xA5. Any other key leaves the configuration unchanged. Bits 31:2 of the configuration always read zero, so the key never reads back.
- R3: With configuration bit 0 (enable) clear, no output differs from its input.
- R4: In the group register at offset 0x4, bits 7:0 select the control target and bits 15:8 select the data target. The value 1 selects the read interface and the value 2 selects the write interface. Any other value selects neither, and the interface that is not selected is never corrupted.
- R5: The control bit code is the 7-bit field at offset 0x8, bits 6:0. Code 0 inverts ACK. Codes 1..32 invert address bit (code-1). Codes 33..48 invert byte-enable bit (code-33). Codes 49..54 invert size bit (code-49). Code 55 inverts READY. Exactly one control signal bit is flipped.
- R6: For the data target with configuration bit 1 clear, bit code n inverts exactly data bit n, for n from 0 to 127.
- R7: With configuration bit 1 (double mode) set, code n inverts data bits n and n+1. Code 127 inverts only bit 127. No more than two data bits are ever flipped.
- R8: Corruption happens only when the interface's valid input is high and its input address equals the 32-bit match register at offset 0xC.
- R9: Control bit codes 56..127 corrupt nothing.
- R10: When both the control target and the data target are set, each fault is applied independently in the same cycle.
- R11: The registers read back as configuration {30'b0, double, enable}, group {16'b0, data, control}, code {25'b0, code} and match address. Offsets other than 0x0, 0x4, 0x8 and 0xC read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| rdValidIn | input | 1 | Read interface access valid |
| rdAddrIn | input | 32 | Read access address from the engine |
| rdAddrOut | output | 32 | Read access address toward the fabric |
| rdByteEnIn | input | 16 | Read byte enables in |
| rdByteEnOut | output | 16 | Read byte enables out |
| rdSizeIn | input | 6 | Read access size in |
| rdSizeOut | output | 6 | Read access size out |
| rdDataIn | input | 128 | Read data returned from the fabric |
| rdDataOut | output | 128 | Read data toward the engine |
| rdAckIn | input | 1 | Read acknowledge from the fabric |
| rdAckOut | output | 1 | Read acknowledge toward the engine |
| rdReadyIn | input | 1 | Read ready from the fabric |
| rdReadyOut | output | 1 | Read ready toward the engine |
| wrValidIn | input | 1 | Write interface access valid |
| wrAddrIn | input | 32 | Write access address from the engine |
| wrAddrOut | output | 32 | Write access address toward the fabric |
| wrByteEnIn | input | 16 | Write byte enables in |
| wrByteEnOut | output | 16 | Write byte enables out |
| wrSizeIn | input | 6 | Write access size in |
| wrSizeOut | output | 6 | Write access size out |
| wrDataIn | input | 128 | Write data from the engine |
| wrDataOut | output | 128 | Write data toward the fabric |
| wrAckIn | input | 1 | Write acknowledge from the fabric |
| wrAckOut | output | 1 | Write acknowledge toward the engine |
| wrReadyIn | input | 1 | Write ready from the fabric |
| wrReadyOut | output | 1 | Write ready toward the engine |

## Verification
The key-guard property assumes that the register offset stays at 0x0 in the cycle after a rejected write. The idle pass-through properties assume that a deasserted valid means no access, whatever the other inputs carry. The stimulus keeps the register write strobe low throughout reset and changes inputs only on falling edges. It sweeps every one of the 128 bit codes for each target group and each mode, with both interfaces driving the match address at once, so that the unselected interface is observed in every step.

// File: rtl/fi_pkg.sv
package fi_pkg;
  localparam int SEL_W = 7;
  localparam logic [7:0] CFG_KEY = 8'hA5;
  localparam logic [7:0] GRP_RD = 8'd1;
  localparam logic [7:0] GRP_WR = 8'd2;
  localparam int NUM_IF = 2;

  // strobes from control to one interface datapath
  typedef struct packed {
    logic             ctlOn;
    logic             dataOn;
    logic             dblBit;
    logic [SEL_W-1:0] bitSel;
  } injStrobe_t;
endpackage

// File: rtl/fi_ctrl.sv
module fi_ctrl
  import fi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [REG_AW-1:0]             regAddr,
  input  logic                          regWrEn,
  input  logic [31:0]                   regWdata,
  output logic [31:0]                   regRdata,
  input  logic [NUM_IF-1:0]             accValid,
  input  logic [NUM_IF-1:0][ADDR_W-1:0] accAddr,
  output injStrobe_t [NUM_IF-1:0]       strobe
);
  localparam logic [REG_AW-1:0] OFF_CFG  = REG_AW'(4'h0);
  localparam logic [REG_AW-1:0] OFF_GRP  = REG_AW'(4'h4);
  localparam logic [REG_AW-1:0] OFF_BIT  = REG_AW'(4'h8);
  localparam logic [REG_AW-1:0] OFF_ADDR = REG_AW'(4'hC);

  logic              cfgEn, cfgDbl;
  logic [7:0]        dataGrp, ctlGrp;
  logic [SEL_W-1:0]  bitSel;
  logic [ADDR_W-1:0] matchAddr;
  logic              keyOk;

  assign keyOk = (regWdata[15:8] == CFG_KEY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEn     <= 1'b0;
      cfgDbl    <= 1'b0;
      dataGrp   <= '0;
      ctlGrp    <= '0;
      bitSel    <= '0;
      matchAddr <= '0;
    end else if (regWrEn) begin
      if (regAddr == OFF_CFG && keyOk) begin
        cfgEn  <= regWdata[0];
        cfgDbl <= regWdata[1];
      end
      if (regAddr == OFF_GRP) begin
        ctlGrp  <= regWdata[7:0];
        dataGrp <= regWdata[15:8];
      end
      if (regAddr == OFF_BIT)  bitSel    <= regWdata[SEL_W-1:0];
      if (regAddr == OFF_ADDR) matchAddr <= regWdata[ADDR_W-1:0];
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      OFF_CFG:  regRdata = {30'b0, cfgDbl, cfgEn};
      OFF_GRP:  regRdata = {16'b0, dataGrp, ctlGrp};
      OFF_BIT:  regRdata = 32'(bitSel);
      OFF_ADDR: regRdata = 32'(matchAddr);
      default:  regRdata = '0;
    endcase
  end

  // per-interface hit detection; interface 0 = read (code 1), 1 = write (code 2)
  for (genvar g = 0; g < NUM_IF; g++) begin : gIf
    localparam logic [7:0] MY_CODE = (g == 0) ? GRP_RD : GRP_WR;
    logic hit;
    assign hit = cfgEn && accValid[g] && (accAddr[g] == matchAddr);
    assign strobe[g].ctlOn  = hit && (ctlGrp == MY_CODE);
    assign strobe[g].dataOn = hit && (dataGrp == MY_CODE);
    assign strobe[g].dblBit = cfgDbl;
    assign strobe[g].bitSel = bitSel;
  end
endmodule

// File: rtl/fi_path.sv
module fi_path
  import fi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 16,
  parameter int SIZE_W = 6,
  parameter int DATA_W = 128
) (
  input  injStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  input  logic [BE_W-1:0]   beIn,
  output logic [BE_W-1:0]   beOut,
  input  logic [SIZE_W-1:0] sizeIn,
  output logic [SIZE_W-1:0] sizeOut,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  input  logic              ackIn,
  output logic              ackOut,
  input  logic              readyIn,
  output logic              readyOut
);
  localparam int ACK_CODE   = 0;
  localparam int ADDR_LO    = ACK_CODE + 1;
  localparam int BE_LO      = ADDR_LO + ADDR_W;
  localparam int SIZE_LO    = BE_LO + BE_W;
  localparam int READY_CODE = SIZE_LO + SIZE_W;

  logic [ADDR_W-1:0] addrMask;
  logic [BE_W-1:0]   beMask;
  logic [SIZE_W-1:0] sizeMask;
  logic [DATA_W-1:0] dataMask;

  for (genvar i = 0; i < ADDR_W; i++) begin : gAddr
    assign addrMask[i] = strobe.ctlOn && (strobe.bitSel == SEL_W'(ADDR_LO + i));
  end
  for (genvar i = 0; i < BE_W; i++) begin : gBe
    assign beMask[i] = strobe.ctlOn && (strobe.bitSel == SEL_W'(BE_LO + i));
  end
  for (genvar i = 0; i < SIZE_W; i++) begin : gSize
    assign sizeMask[i] = strobe.ctlOn && (strobe.bitSel == SEL_W'(SIZE_LO + i));
  end
  for (genvar i = 0; i < DATA_W; i++) begin : gData
    if (i == 0) begin : gLow
      assign dataMask[i] = strobe.dataOn && (strobe.bitSel == SEL_W'(0));
    end else begin : gUp
      // double mode also flips the bit just above the selected one
      assign dataMask[i] = strobe.dataOn &&
                           ((strobe.bitSel == SEL_W'(i)) ||
                            (strobe.dblBit && (strobe.bitSel == SEL_W'(i - 1))));
    end
  end

  assign addrOut  = addrIn ^ addrMask;
  assign beOut    = beIn ^ beMask;
  assign sizeOut  = sizeIn ^ sizeMask;
  assign dataOut  = dataIn ^ dataMask;
  assign ackOut   = ackIn ^ (strobe.ctlOn && (strobe.bitSel == SEL_W'(ACK_CODE)));
  assign readyOut = readyIn ^ (strobe.ctlOn && (strobe.bitSel == SEL_W'(READY_CODE)));
endmodule

// File: rtl/fi_top.sv
module fi_top
  import fi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 16,
  parameter int SIZE_W = 6,
  parameter int DATA_W = 128,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              rdValidIn,
  input  logic [ADDR_W-1:0] rdAddrIn,
  output logic [ADDR_W-1:0] rdAddrOut,
  input  logic [BE_W-1:0]   rdByteEnIn,
  output logic [BE_W-1:0]   rdByteEnOut,
  input  logic [SIZE_W-1:0] rdSizeIn,
  output logic [SIZE_W-1:0] rdSizeOut,
  input  logic [DATA_W-1:0] rdDataIn,
  output logic [DATA_W-1:0] rdDataOut,
  input  logic              rdAckIn,
  output logic              rdAckOut,
  input  logic              rdReadyIn,
  output logic              rdReadyOut,
  input  logic              wrValidIn,
  input  logic [ADDR_W-1:0] wrAddrIn,
  output logic [ADDR_W-1:0] wrAddrOut,
  input  logic [BE_W-1:0]   wrByteEnIn,
  output logic [BE_W-1:0]   wrByteEnOut,
  input  logic [SIZE_W-1:0] wrSizeIn,
  output logic [SIZE_W-1:0] wrSizeOut,
  input  logic [DATA_W-1:0] wrDataIn,
  output logic [DATA_W-1:0] wrDataOut,
  input  logic              wrAckIn,
  output logic              wrAckOut,
  input  logic              wrReadyIn,
  output logic              wrReadyOut
);
  injStrobe_t [NUM_IF-1:0] strobe;

  fi_ctrl #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .accValid ({wrValidIn, rdValidIn}),
    .accAddr  ({wrAddrIn, rdAddrIn}),
    .strobe   (strobe)
  );

  fi_path #(.ADDR_W(ADDR_W), .BE_W(BE_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W)) uRdPath (
    .strobe (strobe[0]),
    .addrIn (rdAddrIn),   .addrOut (rdAddrOut),
    .beIn   (rdByteEnIn), .beOut   (rdByteEnOut),
    .sizeIn (rdSizeIn),   .sizeOut (rdSizeOut),
    .dataIn (rdDataIn),   .dataOut (rdDataOut),
    .ackIn  (rdAckIn),    .ackOut  (rdAckOut),
    .readyIn(rdReadyIn),  .readyOut(rdReadyOut)
  );

  fi_path #(.ADDR_W(ADDR_W), .BE_W(BE_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W)) uWrPath (
    .strobe (strobe[1]),
    .addrIn (wrAddrIn),   .addrOut (wrAddrOut),
    .beIn   (wrByteEnIn), .beOut   (wrByteEnOut),
    .sizeIn (wrSizeIn),   .sizeOut (wrSizeOut),
    .dataIn (wrDataIn),   .dataOut (wrDataOut),
    .ackIn  (wrAckIn),    .ackOut  (wrAckOut),
    .readyIn(wrReadyIn),  .readyOut(wrReadyOut)
  );
endmodule

// File: rtl/fi_chk.sv
module fi_chk #(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 16,
  parameter int SIZE_W = 6,
  parameter int DATA_W = 128,
  parameter int REG_AW = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [REG_AW-1:0] regAddr,
  input logic              regWrEn,
  input logic [31:0]       regWdata,
  input logic [31:0]       regRdata,
  input logic              rdValidIn,
  input logic [ADDR_W-1:0] rdAddrIn,
  input logic [ADDR_W-1:0] rdAddrOut,
  input logic [BE_W-1:0]   rdByteEnIn,
  input logic [BE_W-1:0]   rdByteEnOut,
  input logic [SIZE_W-1:0] rdSizeIn,
  input logic [SIZE_W-1:0] rdSizeOut,
  input logic [DATA_W-1:0] rdDataIn,
  input logic [DATA_W-1:0] rdDataOut,
  input logic              rdAckIn,
  input logic              rdAckOut,
  input logic              rdReadyIn,
  input logic              rdReadyOut,
  input logic              wrValidIn,
  input logic [ADDR_W-1:0] wrAddrIn,
  input logic [ADDR_W-1:0] wrAddrOut,
  input logic [DATA_W-1:0] wrDataIn,
  input logic [DATA_W-1:0] wrDataOut,
  input logic              wrAckIn,
  input logic              wrAckOut
);
  AST_CFG_KEY_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regWrEn && regAddr == '0 && regWdata[15:8] != 8'hA5) && regAddr == '0)
      |-> regRdata == $past(regRdata)); // R2

  AST_CFG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == '0) |-> (regRdata[31:2] == '0)); // R11

  AST_RD_IDLE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    !rdValidIn |-> (rdDataOut == rdDataIn && rdAddrOut == rdAddrIn &&
                    rdAckOut == rdAckIn && rdReadyOut == rdReadyIn &&
                    rdByteEnOut == rdByteEnIn && rdSizeOut == rdSizeIn)); // R8

  AST_WR_IDLE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    !wrValidIn |-> (wrDataOut == wrDataIn && wrAddrOut == wrAddrIn &&
                    wrAckOut == wrAckIn)); // R8

  AST_DATA_FLIP_MAX2: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(rdDataOut ^ rdDataIn) <= 2) && ($countones(wrDataOut ^ wrDataIn) <= 2)); // R7

  AST_CTL_FLIP_MAX1: assert property (@(posedge clk) disable iff (!rstN)
    $countones({rdAckOut ^ rdAckIn, rdReadyOut ^ rdReadyIn, rdAddrOut ^ rdAddrIn,
                rdByteEnOut ^ rdByteEnIn, rdSizeOut ^ rdSizeIn}) <= 1); // R5
endmodule

bind fi_top fi_chk #(
  .ADDR_W(ADDR_W), .BE_W(BE_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W), .REG_AW(REG_AW)
) uChk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWdata(regWdata), .regRdata(regRdata),
  .rdValidIn(rdValidIn), .rdAddrIn(rdAddrIn), .rdAddrOut(rdAddrOut),
  .rdByteEnIn(rdByteEnIn), .rdByteEnOut(rdByteEnOut),
  .rdSizeIn(rdSizeIn), .rdSizeOut(rdSizeOut),
  .rdDataIn(rdDataIn), .rdDataOut(rdDataOut),
  .rdAckIn(rdAckIn), .rdAckOut(rdAckOut),
  .rdReadyIn(rdReadyIn), .rdReadyOut(rdReadyOut),
  .wrValidIn(wrValidIn), .wrAddrIn(wrAddrIn), .wrAddrOut(wrAddrOut),
  .wrDataIn(wrDataIn), .wrDataOut(wrDataOut),
  .wrAckIn(wrAckIn), .wrAckOut(wrAckOut)
);

// File: tb/tb_fi_top.sv
`timescale 1ns/1ps
module tb_fi_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic [3:0]   regAddr = '0;
  logic         regWrEn = 1'b0;
  logic [31:0]  regWdata = '0;
  logic [31:0]  regRdata;
  logic         rdValidIn = 0, wrValidIn = 0;
  logic [31:0]  rdAddrIn = '0, wrAddrIn = '0, rdAddrOut, wrAddrOut;
  logic [15:0]  rdByteEnIn = '0, wrByteEnIn = '0, rdByteEnOut, wrByteEnOut;
  logic [5:0]   rdSizeIn = '0, wrSizeIn = '0, rdSizeOut, wrSizeOut;
  logic [127:0] rdDataIn = '0, wrDataIn = '0, rdDataOut, wrDataOut;
  logic         rdAckIn = 0, wrAckIn = 0, rdAckOut, wrAckOut;
  logic         rdReadyIn = 0, wrReadyIn = 0, rdReadyOut, wrReadyOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] MATCH = 32'h2000_4A10;

  fi_top dut (.*);

  task automatic note(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic checkReg(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    regAddr = a;
    #1;
    note(regRdata == exp, req, $sformatf("reg@%h", a), 128'(regRdata), 128'(exp));
  endtask

  task automatic driveBus(input bit v, input logic [31:0] addr, input int seed);
    rdValidIn = v; wrValidIn = v;
    rdAddrIn = addr; wrAddrIn = addr;
    rdByteEnIn = 16'h5A00 ^ 16'(seed); wrByteEnIn = ~(16'h5A00 ^ 16'(seed));
    rdSizeIn = 6'(seed * 3); wrSizeIn = ~6'(seed * 5);
    rdDataIn = {4{32'hC3A5_0000 ^ 32'(seed * 7919)}};
    wrDataIn = ~{4{32'h1E2D_0000 ^ 32'(seed * 104729)}};
    rdAckIn = seed[0]; wrAckIn = ~seed[1];
    rdReadyIn = seed[1]; wrReadyIn = seed[0];
  endtask

  // compare one interface against input XOR expected masks
  task automatic checkBus(input string req, input bit wrSide, input logic [127:0] dM,
                          input logic [31:0] aM, input logic [15:0] bM, input logic [5:0] sM,
                          input logic aF, input logic rF);
    logic ok;
    logic [127:0] act, exp;
    #1;
    if (!wrSide) begin
      ok = rdDataOut == (rdDataIn ^ dM) && rdAddrOut == (rdAddrIn ^ aM) &&
           rdByteEnOut == (rdByteEnIn ^ bM) && rdSizeOut == (rdSizeIn ^ sM) &&
           rdAckOut == (rdAckIn ^ aF) && rdReadyOut == (rdReadyIn ^ rF);
      act = rdDataOut ^ {rdAddrOut, rdByteEnOut, rdSizeOut, rdAckOut, rdReadyOut};
      exp = (rdDataIn ^ dM) ^ {rdAddrIn ^ aM, rdByteEnIn ^ bM, rdSizeIn ^ sM,
                                rdAckIn ^ aF, rdReadyIn ^ rF};
    end else begin
      ok = wrDataOut == (wrDataIn ^ dM) && wrAddrOut == (wrAddrIn ^ aM) &&
           wrByteEnOut == (wrByteEnIn ^ bM) && wrSizeOut == (wrSizeIn ^ sM) &&
           wrAckOut == (wrAckIn ^ aF) && wrReadyOut == (wrReadyIn ^ rF);
      act = wrDataOut ^ {wrAddrOut, wrByteEnOut, wrSizeOut, wrAckOut, wrReadyOut};
      exp = (wrDataIn ^ dM) ^ {wrAddrIn ^ aM, wrByteEnIn ^ bM, wrSizeIn ^ sM,
                                wrAckIn ^ aF, wrReadyIn ^ rF};
    end
    note(ok, req, wrSide ? "wr bus" : "rd bus", act, exp);
  endtask

  task automatic checkClean(input string req);
    checkBus(req, 0, '0, '0, '0, '0, 0, 0);
    checkBus(req, 1, '0, '0, '0, '0, 0, 0);
  endtask

  function automatic void ctlExp(input int c, output logic [31:0] aM, output logic [15:0] bM,
                                 output logic [5:0] sM, output logic aF, output logic rF);
    aM = '0; bM = '0; sM = '0; aF = 0; rF = 0;
    if (c == 0) aF = 1;
    else if (c <= 32) aM[c-1] = 1'b1;
    else if (c <= 48) bM[c-33] = 1'b1;
    else if (c <= 54) sM[c-49] = 1'b1;
    else if (c == 55) rF = 1;
  endfunction

  initial begin
    logic [31:0] aM; logic [15:0] bM; logic [5:0] sM; logic aF, rF;
    logic [127:0] dM;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R1: reset values and transparent bus
    checkReg(4'h0, 32'h0, "R1");
    checkReg(4'h4, 32'h0, "R1");
    checkReg(4'h8, 32'h0, "R1");
    checkReg(4'hC, 32'h0, "R1");
    driveBus(1, 32'h0, 9);
    checkClean("R1");

    // R2: key guard
    regWrite(4'h0, 32'h0000_5A03);
    checkReg(4'h0, 32'h0, "R2");
    regWrite(4'h0, 32'hFFFF_A503);
    checkReg(4'h0, 32'h3, "R2");
    regWrite(4'h0, 32'h0000_0000);
    checkReg(4'h0, 32'h3, "R2");

    // R11: readback layout and unlisted offsets
    regWrite(4'h4, 32'hFFFF_0201);
    checkReg(4'h4, 32'h0000_0201, "R11");
    regWrite(4'h8, 32'hFFFF_FFFF);
    checkReg(4'h8, 32'h0000_007F, "R11");
    regWrite(4'hC, MATCH);
    checkReg(4'hC, MATCH, "R11");
    regWrite(4'h1, 32'hFFFF_FFFF);
    regWrite(4'h6, 32'h0000_0000);
    checkReg(4'h1, 32'h0, "R11");
    checkReg(4'h4, 32'h0000_0201, "R11");
    checkReg(4'h8, 32'h0000_007F, "R11");
    checkReg(4'hC, MATCH, "R11");

    // R5 / R9 / R4: control sweep on each interface
    regWrite(4'h0, 32'h0000_A501);
    for (int g = 1; g <= 2; g++) begin
      regWrite(4'h4, 32'(g));
      for (int c = 0; c < 128; c++) begin
        regWrite(4'h8, 32'(c));
        driveBus(1, MATCH, c);
        ctlExp(c, aM, bM, sM, aF, rF);
        checkBus(c > 55 ? "R9" : "R5", g == 2, '0, aM, bM, sM, aF, rF);
        checkBus("R4", g == 1, '0, '0, '0, '0, 0, 0);
      end
    end

    // R6 / R7 / R4: data sweep, single and double mode
    for (int dbl = 0; dbl < 2; dbl++) begin
      regWrite(4'h0, 32'h0000_A501 | 32'(dbl << 1));
      for (int g = 1; g <= 2; g++) begin
        regWrite(4'h4, 32'(g) << 8);
        for (int c = 0; c < 128; c++) begin
          regWrite(4'h8, 32'(c));
          driveBus(1, MATCH, c + 300);
          dM = 128'(1) << c;
          if (dbl == 1 && c < 127) dM = dM | (128'(1) << (c + 1));
          checkBus(dbl == 1 ? "R7" : "R6", g == 2, dM, '0, '0, '0, 0, 0);
          checkBus("R4", g == 1, '0, '0, '0, '0, 0, 0);
        end
      end
    end

    // R10: both groups on the read interface at once
    regWrite(4'h0, 32'h0000_A501);
    regWrite(4'h4, 32'h0000_0101);
    regWrite(4'h8, 32'd5);
    driveBus(1, MATCH, 42);
    checkBus("R10", 0, 128'h20, 32'h10, '0, '0, 0, 0);
    checkBus("R10", 1, '0, '0, '0, '0, 0, 0);

    // R8: address mismatch and invalid access
    driveBus(1, MATCH ^ 32'h8000_0000, 43);
    checkClean("R8");
    driveBus(1, MATCH ^ 32'h1, 44);
    checkClean("R8");
    driveBus(0, MATCH, 45);
    checkClean("R8");

    // R4: reserved group codes select nothing
    regWrite(4'h4, 32'h0000_0303);
    driveBus(1, MATCH, 46);
    checkClean("R4");
    regWrite(4'h4, 32'h0000_FFFF);
    driveBus(1, MATCH, 47);
    checkClean("R4");

    // R3: enable clear means no corruption
    regWrite(4'h4, 32'h0000_0101);
    regWrite(4'h0, 32'h0000_A500);
    checkReg(4'h0, 32'h0, "R3");
    for (int c = 0; c < 128; c += 9) begin
      regWrite(4'h8, 32'(c));
      driveBus(1, MATCH, c + 77);
      checkClean("R3");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule